// File: doc/BRIEF.md
# PHY Event Interrupt Controller

This block gathers change events from a transceiver's link and speed monitors and turns them into an interrupt on a shared pin. Each monitor delivers a one-cycle pulse. The pulse sets a sticky bit in a 16-bit status word. Software clears that bit by reading the status word. The same word also holds a read/write enable bit for each event.

A 16-bit control word gates the interrupt in three ways:
- a global interrupt enable;
- an output enable that turns the shared pin into an interrupt driver;
- a polarity select.

The control word also has a test bit that forces the interrupt for as long as it is set. When the output enable is clear, the pin is released (tri-stated) so it can serve as a power-down input. The interrupt level is still computed internally in that case.

Software reaches both words through a simple register port: an address, a write strobe, a read strobe and 16-bit data. Read data is registered and valid on the cycle after the read strobe. The interrupt pin and its output enable are also registered.

Top module: `phy_evt_irq_ctrl`

## Requirements
- R1: A pulse on `evt_pulse[1]` (link change) sets status bit 13. A pulse on `evt_pulse[0]` (speed change) sets status bit 12. Each bit is set on the clock edge of the pulse, whether or not its enable bit is set.
- R2: A read of the status word (address 1) returns it on `reg_rdata` after the read edge. The same read clears bits 13 and 12, and a second read returns them as zero.
- R3: If an event pulse coincides with a status read, the read returns the old value and the event's bit is set after the read.
- R4: Reserved bits read as zero and ignore writes. In the status word these are bits 15:14, 11:6 and 3:0. In the control word (address 0) they are bits 15:12, 10 and 7:5. Addresses 2 and 3 read as zero.
- R5: The control word resets to 0x0108. Bits 11, 9:8 and 4 are plain read/write bits, so writing 0xFFFF reads back 0x0B1F.
- R6: The interrupt is active when the global enable (control bit 1) is set and some status bit is set together with its enable bit. It goes inactive one cycle after a status read that leaves no enabled event set.
- R7: With control bit 3 set, the pin idles at 1 and is 0 while the interrupt is active. With bit 3 clear, it idles at 0 and is 1 while active. `irq_o` follows the control and status state with one cycle of latency.
- R8: Control bit 2 forces the interrupt active, regardless of the event enables and the global enable, for as long as it stays set.
- R9: `irq_oe` equals control bit 0, delayed by one cycle. When it is low, the pin is released, but `irq_o` still carries the computed interrupt level.
- R10: Status bits 5 (link) and 4 (speed) are read/write event enables. They reset to 0 and a status read does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (status read clears events) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| evt_pulse | input | 2 | One-cycle event pulses: bit 1 link, bit 0 speed |
| irq_o | output | 1 | Interrupt pin level after polarity |
| irq_oe | output | 1 | Pin output enable; low releases the pin |

## Verification
The assertions assume the following about the inputs:
- event inputs are single-cycle pulses sampled on the clock edge;
- read and write strobes are never asserted in the same cycle;
- the address is stable while a strobe is high.

The bench drives every input on the falling edge, and each strobe and each pulse lasts exactly one cycle. Strobes are issued only through its register tasks, which never combine a read and a write. The one deliberate overlap is an event pulse raised together with a status read, and the assertions allow for that case.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  // Status word layout
  localparam int STAT_LSB  = 12;   // event status bits start here
  localparam int EN_LSB    = 4;    // event enable bits start here
  // Control word bit positions
  localparam int CB_OE     = 0;
  localparam int CB_INT_EN = 1;
  localparam int CB_TEST   = 2;
  localparam int CB_POL    = 3;
  localparam logic [15:0] CTRL_RST  = 16'h0108;
  localparam logic [15:0] CTRL_MASK = 16'h0B1F;
  // Register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import phy_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam logic [DATA_W-1:0] RST_V  = DATA_W'(CTRL_RST);
  localparam logic [DATA_W-1:0] MASK_V = DATA_W'(CTRL_MASK);

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= RST_V;
    else if (wr_en) ctrl_q <= wdata & MASK_V;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(ctrl_q)); // R5
endmodule

// File: rtl/irq_evt_status.sv
module irq_evt_status #(
  parameter int N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt,
  input  logic             rd_clr,
  input  logic             en_wr,
  input  logic [N_EVT-1:0] en_wdata,
  output logic [N_EVT-1:0] stat_q,
  output logic [N_EVT-1:0] en_q
);
  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst) stat_q[g] <= 1'b0;
      else     stat_q[g] <= evt[g] | (stat_q[g] & ~rd_clr);
    end

    always_ff @(posedge clk) begin
      if (rst)        en_q[g] <= 1'b0;
      else if (en_wr) en_q[g] <= en_wdata[g];
    end

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
      evt[g] |=> stat_q[g]); // R1
    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && !evt[g]) |=> !stat_q[g]); // R2
    AST_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && evt[g]) |=> (stat_q[g] && $stable(en_q[g]))); // R3
    AST_EN_KEEP: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && !en_wr) |=> $stable(en_q[g])); // R10
  end
endmodule

// File: rtl/irq_out.sv
module irq_out #(
  parameter int N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] stat,
  input  logic [N_EVT-1:0] en,
  input  logic             int_en,
  input  logic             test,
  input  logic             pol,
  input  logic             oe,
  output logic             irq_o,
  output logic             irq_oe
);
  logic evt_hit;
  logic active;

  assign evt_hit = |(stat & en);
  assign active  = (int_en & evt_hit) | test;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b1;
      irq_oe <= 1'b0;
    end else begin
      irq_o  <= active ^ pol;
      irq_oe <= oe;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (!$past(int_en) && !$past(test)) |-> (irq_o == $past(pol))); // R6
  AST_IRQ_NO_EVT: assert property (@(posedge clk) disable iff (rst)
    ($past(stat) == '0 && !$past(test)) |-> (irq_o == $past(pol))); // R7
  AST_TEST_FORCE: assert property (@(posedge clk) disable iff (rst)
    $past(test) |-> (irq_o != $past(pol))); // R8
  AST_OE_TRACK: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_oe) |-> $past(oe)); // R9
endmodule

// File: rtl/phy_evt_irq_ctrl.sv
module phy_evt_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int N_EVT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_EVT-1:0]  evt_pulse,
  output logic              irq_o,
  output logic              irq_oe
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic              sel_ctrl, sel_stat;
  logic [DATA_W-1:0] ctrl_q;
  logic [N_EVT-1:0]  stat_q, en_q;
  logic [DATA_W-1:0] stat_word, rd_mux;

  assign sel_ctrl = (reg_addr == A_CTRL);
  assign sel_stat = (reg_addr == A_STAT);

  irq_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr & sel_ctrl),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q)
  );

  irq_evt_status #(.N_EVT(N_EVT)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_pulse),
    .rd_clr   (reg_rd & sel_stat),
    .en_wr    (reg_wr & sel_stat),
    .en_wdata (reg_wdata[EN_LSB +: N_EVT]),
    .stat_q   (stat_q),
    .en_q     (en_q)
  );

  irq_out #(.N_EVT(N_EVT)) u_out (
    .clk    (clk),
    .rst    (rst),
    .stat   (stat_q),
    .en     (en_q),
    .int_en (ctrl_q[CB_INT_EN]),
    .test   (ctrl_q[CB_TEST]),
    .pol    (ctrl_q[CB_POL]),
    .oe     (ctrl_q[CB_OE]),
    .irq_o  (irq_o),
    .irq_oe (irq_oe)
  );

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < N_EVT; i++) begin
      stat_word[STAT_LSB + i] = stat_q[i];
      stat_word[EN_LSB + i]   = en_q[i];
    end
  end

  always_comb begin
    if (sel_ctrl)      rd_mux = ctrl_q;
    else if (sel_stat) rd_mux = stat_word;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[15:14] == 2'b00 && !reg_rdata[10] && reg_rdata[7:6] == 2'b00)); // R4
  AST_STAT_RD_VAL: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel_stat) |=> (reg_rdata[STAT_LSB +: N_EVT] == $past(stat_q))); // R2
endmodule

// File: tb/phy_evt_irq_ctrl_tb_top.sv
module phy_evt_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  evt_pulse = '0;
  logic        irq_o, irq_oe;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  phy_evt_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // {ctrl[15:0], en[1:0], evt[1:0], exp_irq, exp_oe, exp_stat[15:0]}
  localparam logic [37:0] VEC [0:7] = '{
    {16'h000B, 2'b11, 2'b10, 1'b0, 1'b1, 16'h2000},
    {16'h000B, 2'b01, 2'b10, 1'b1, 1'b1, 16'h2000},
    {16'h0003, 2'b01, 2'b01, 1'b1, 1'b1, 16'h1000},
    {16'h0009, 2'b11, 2'b11, 1'b1, 1'b1, 16'h3000},
    {16'h000A, 2'b11, 2'b10, 1'b0, 1'b0, 16'h2000},
    {16'h0004, 2'b00, 2'b00, 1'b1, 1'b0, 16'h0000},
    {16'h000D, 2'b00, 2'b01, 1'b0, 1'b1, 16'h1000},
    {16'h0002, 2'b10, 2'b11, 1'b1, 1'b0, 16'h3000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [1:0] ev, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1; evt_pulse = ev;
    cyc();
    reg_rd = 1'b0; evt_pulse = '0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [1:0] ev);
    evt_pulse = ev;
    cyc();
    evt_pulse = '0;
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    chk("R7 reset idle level", {15'd0, irq_o}, 16'd1);
    chk("R9 reset oe", {15'd0, irq_oe}, 16'd0);
    rd(2'd0, 2'b00, d); chk("R5 ctrl reset", d, 16'h0108);
    rd(2'd1, 2'b00, d); chk("R10 status reset", d, 16'h0000);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      logic [15:0] c, st;
      logic [1:0]  en, ev;
      logic        ei, eo;
      {c, en, ev, ei, eo, st} = VEC[i];
      wr(2'd0, c);
      wr(2'd1, {10'd0, en, 4'd0});
      pulse(ev);
      cyc();
      chk($sformatf("R6/R7/R8 vec %0d irq", i), {15'd0, irq_o}, {15'd0, ei});
      chk($sformatf("R9 vec %0d oe", i), {15'd0, irq_oe}, {15'd0, eo});
      rd(2'd1, 2'b00, d);
      chk($sformatf("R1 vec %0d status", i), d, st | {10'd0, en, 4'd0});
      cyc();
      chk($sformatf("R6 vec %0d after read", i), {15'd0, irq_o}, {15'd0, c[2] ^ c[3]});
      rd(2'd1, 2'b00, d);
      chk($sformatf("R2 vec %0d cleared", i), d, {10'd0, en, 4'd0});
    end

    // Reserved and plain bits
    wr(2'd0, 16'hFFFF);
    rd(2'd0, 2'b00, d); chk("R4/R5 ctrl mask", d, 16'h0B1F);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, 2'b00, d); chk("R4/R10 status write", d, 16'h0030);
    rd(2'd2, 2'b00, d); chk("R4 unmapped addr", d, 16'h0000);

    // Event coinciding with a status read
    wr(2'd0, 16'h000B);
    wr(2'd1, 16'h0020);
    pulse(2'b10);
    rd(2'd1, 2'b10, d); chk("R3 read with event old value", d, 16'h2020);
    cyc();
    chk("R3 irq still active", {15'd0, irq_o}, 16'd0);
    rd(2'd1, 2'b00, d); chk("R3 event kept", d, 16'h2020);
    rd(2'd1, 2'b00, d); chk("R2 cleared after read", d, 16'h0020);
    cyc();
    chk("R6 deasserted", {15'd0, irq_o}, 16'd1);

    // Test bit held
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h000D);
    for (int k = 0; k < 10; k++) begin
      cyc();
      chk("R8 test hold", {15'd0, irq_o}, 16'd0);
    end
    wr(2'd0, 16'h0009);
    cyc();
    chk("R8 test released", {15'd0, irq_o}, 16'd1);
    wr(2'd0, 16'h0000);
    cyc();
    chk("R9 oe released", {15'd0, irq_oe}, 16'd0);
    chk("R7 active-high idle", {15'd0, irq_o}, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule